// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps one small write-back cache coherent with its peers on a shared bus. It holds a direct-mapped array of one-word blocks. Each block is in one of three states: invalid, shared or modified. The processor side issues reads and writes and holds each request until the block signals completion. Reads that hit, and writes that hit a modified block, finish locally without any bus traffic. Misses, upgrades and write-backs go out as bus transactions. Each transaction is held until the bus acknowledges it.

The block also watches every transaction that other caches place on the bus, and reacts in the same cycle:
- **Read miss hitting a modified block here:** the cache drives the block's data and raises a cancel line. Memory then discards its own reply and stores the supplied word instead. Both copies end up shared.
- **Read-for-ownership or invalidation of a held block:** the local copy is dropped.

Snoops take precedence. A local request that meets a snoop in the same cycle waits until the snoop has been handled.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every block is invalid. The first local read to any address misses, and a snoop to any address gets no cancel.
- R2: A local read miss issues one bus read (command code 01) to the requested address. The returned word is delivered to the processor and the block becomes shared. Bus command codes are: write-back 00, read 01, read-for-ownership 10, invalidate 11.
- R3: Writes are write-back. A write that hits a modified block completes with no bus transaction. A write miss issues a read-for-ownership (10) and leaves the block modified with the written value.
- R4: A local write to a shared block issues an invalidate (11), which carries no data, and then completes with the block modified.
- R5: A snooped read-for-ownership or invalidate to a block held here makes the local copy invalid, so the next local access to it misses.
- R6: A snooped read (01) to a block held modified raises the cancel output and drives the block's value in that same cycle. The block becomes shared, so a later local write needs an invalidate.
- R7: A snooped read-for-ownership (10) to a block held modified raises the cancel output and drives the block's value. The local copy becomes invalid.
- R8: A snoop to a block that is shared, invalid or not held never raises the cancel output.
- R9: A miss whose slot holds a modified block of another address first writes that block back (00) with its address and value, then fetches. A shared victim is replaced with no write-back.
- R10: In a cycle with a snoop, no local request completes. A stalled request completes after the snoop.
- R11: If a pending invalidate loses its block to a snooped invalidation before being acknowledged, the request is reissued as a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReq | output | 1 | Bus transaction pending |
| busCmd | output | 2 | Transaction code (00 write-back, 01 read, 10 read-for-ownership, 11 invalidate) |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Write-back data |
| busAck | input | 1 | Bus completes the pending transaction |
| busRdata | input | DATA_W | Fill data, valid with busAck |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped transaction code |
| snpAddr | input | ADDR_W | Snooped address |
| snpAbort | output | 1 | Cancels memory's reply; memory captures snpData |
| snpData | output | DATA_W | Block value supplied on intervention |

## Verification
The bound checker examines the following on every cycle:
- no completion during a snoop;
- the cancel output only during a snoop, and never twice in a row for one address;
- no bus request while a local hit completes or without a processor request;
- read-for-ownership and invalidate only on behalf of writes, reads only for reads.

Only the bench scenarios can show the rest, because it depends on stored state and data:
- the value supplied on intervention and the state left after it;
- the order of write-back before refill;
- the silent eviction of a shared block;
- the conversion of a lost upgrade into a read-for-ownership.

A reference model of the blocks and of memory predicts each transaction list and each returned word.

// File: rtl/coh_pkg.sv
package coh_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_MOD = 2'b10
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_WB  = 2'b00,
    BUS_RD  = 2'b01,
    BUS_RDX = 2'b10,
    BUS_UPG = 2'b11
  } busCmd_t;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_WBACK,
    CTL_FETCH,
    CTL_UPGR
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       lineWr;      // write state+tag of the processor-indexed slot
    lineState_t lineNext;
    logic       dataWr;      // write data of the processor-indexed slot
    logic       dataFromBus; // 1: fill from bus, 0: processor write data
    logic       snpWr;       // write state of the snoop-indexed slot
    lineState_t snpNext;
  } dpStrobe_t;
endpackage

// File: rtl/coh_dpath.sv
module coh_dpath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [ADDR_W-1:0] snpAddr,
  output lineState_t        cpuState,
  output lineState_t        victimState,
  output lineState_t        snpState,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData,
  output logic [DATA_W-1:0] snpLineData
);
  timeunit 1ns; timeprecision 100ps;

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stArr  [LINES];
  logic [TAG_W-1:0]  tagArr [LINES];
  logic [DATA_W-1:0] datArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // state array: processor-side write wins (control never issues both to one slot)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LINE_INV;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strb.lineWr && cpuIdx == IDX_W'(i))
          stArr[i] <= strb.lineNext;
        else if (strb.snpWr && snpIdx == IDX_W'(i))
          stArr[i] <= strb.snpNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (strb.lineWr && cpuIdx == IDX_W'(i))
        tagArr[i] <= cpuTag;
      if (strb.dataWr && cpuIdx == IDX_W'(i))
        datArr[i] <= strb.dataFromBus ? busRdata : cpuWdata;
    end
  end

  always_comb begin
    victimState = stArr[cpuIdx];
    victimAddr  = {tagArr[cpuIdx], cpuIdx};
    lineData    = datArr[cpuIdx];
    cpuState    = (stArr[cpuIdx] != LINE_INV && tagArr[cpuIdx] == cpuTag)
                  ? stArr[cpuIdx] : LINE_INV;
    snpState    = (stArr[snpIdx] != LINE_INV && tagArr[snpIdx] == snpTag)
                  ? stArr[snpIdx] : LINE_INV;
    snpLineData = datArr[snpIdx];
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       busAck,
  input  logic       snpValid,
  input  busCmd_t    snpCmd,
  input  lineState_t cpuState,
  input  lineState_t victimState,
  input  lineState_t snpState,
  output dpStrobe_t  strb,
  output logic       cpuReady,
  output logic       busReq,
  output busCmd_t    busCmd,
  output logic       busUseVictim,
  output logic       snpAbort
);
  timeunit 1ns; timeprecision 100ps;

  ctlState_t cur, nxt;

  always_ff @(posedge clk) begin
    if (rst) cur <= CTL_IDLE;
    else     cur <= nxt;
  end

  always_comb begin
    strb         = '0;
    cpuReady     = 1'b0;
    busReq       = 1'b0;
    busCmd       = BUS_RD;
    busUseVictim = 1'b0;
    snpAbort     = 1'b0;
    nxt          = cur;

    // snoop response: same cycle
    if (snpValid) begin
      case (snpCmd)
        BUS_RD: if (snpState == LINE_MOD) begin
          snpAbort     = 1'b1;
          strb.snpWr   = 1'b1;
          strb.snpNext = LINE_SHR;
        end
        BUS_RDX, BUS_UPG: if (snpState != LINE_INV) begin
          snpAbort     = (snpCmd == BUS_RDX) && (snpState == LINE_MOD);
          strb.snpWr   = 1'b1;
          strb.snpNext = LINE_INV;
        end
        default: ;
      endcase
    end

    // local side: held off while a snoop is present
    case (cur)
      CTL_IDLE: if (cpuReq && !snpValid) begin
        if (cpuState == LINE_MOD || (cpuState == LINE_SHR && !cpuWe)) begin
          cpuReady         = 1'b1;
          strb.dataWr      = cpuWe;
          strb.dataFromBus = 1'b0;
        end else if (cpuState == LINE_SHR) begin
          nxt = CTL_UPGR;
        end else if (victimState == LINE_MOD) begin
          nxt = CTL_WBACK;
        end else begin
          nxt = CTL_FETCH;
        end
      end
      CTL_WBACK: begin
        busCmd       = BUS_WB;
        busUseVictim = 1'b1;
        if (victimState != LINE_MOD) begin
          if (!snpValid) nxt = CTL_FETCH;
        end else begin
          busReq = 1'b1;
          if (busAck && !snpValid) begin
            strb.lineWr   = 1'b1;
            strb.lineNext = LINE_INV;
            nxt           = CTL_FETCH;
          end
        end
      end
      CTL_FETCH: begin
        busReq = 1'b1;
        busCmd = cpuWe ? BUS_RDX : BUS_RD;
        if (busAck && !snpValid) begin
          strb.lineWr      = 1'b1;
          strb.lineNext    = cpuWe ? LINE_MOD : LINE_SHR;
          strb.dataWr      = 1'b1;
          strb.dataFromBus = 1'b1;
          nxt              = CTL_IDLE;
        end
      end
      CTL_UPGR: begin
        busCmd = BUS_UPG;
        if (cpuState != LINE_SHR) begin
          if (!snpValid) nxt = CTL_FETCH;
        end else begin
          busReq = 1'b1;
          if (busAck && !snpValid) begin
            strb.lineWr   = 1'b1;
            strb.lineNext = LINE_MOD;
            nxt           = CTL_IDLE;
          end
        end
      end
      default: nxt = CTL_IDLE;
    endcase
  end
endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpAbort,
  output logic [DATA_W-1:0] snpData
);
  timeunit 1ns; timeprecision 100ps;

  dpStrobe_t         strb;
  lineState_t        cpuState, victimState, snpState;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] lineData, snpLineData;
  busCmd_t           busCmdE;
  logic              busUseVictim;

  coh_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpuReq      (cpuReq),
    .cpuWe       (cpuWe),
    .busAck      (busAck),
    .snpValid    (snpValid),
    .snpCmd      (busCmd_t'(snpCmd)),
    .cpuState    (cpuState),
    .victimState (victimState),
    .snpState    (snpState),
    .strb        (strb),
    .cpuReady    (cpuReady),
    .busReq      (busReq),
    .busCmd      (busCmdE),
    .busUseVictim(busUseVictim),
    .snpAbort    (snpAbort)
  );

  coh_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .busRdata   (busRdata),
    .snpAddr    (snpAddr),
    .cpuState   (cpuState),
    .victimState(victimState),
    .snpState   (snpState),
    .victimAddr (victimAddr),
    .lineData   (lineData),
    .snpLineData(snpLineData)
  );

  assign busCmd   = busCmdE;
  assign busAddr  = busUseVictim ? victimAddr : cpuAddr;
  assign busWdata = lineData;
  assign cpuRdata = lineData;
  assign snpData  = snpAbort ? snpLineData : '0;
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic              snpValid,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpAbort
);
  timeunit 1ns; timeprecision 100ps;

  // R10
  stall_on_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snpValid |-> !cpuReady);

  // R8
  abort_in_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snpAbort |-> snpValid);

  // R3
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> !busReq);

  // R2
  bus_for_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    busReq |-> cpuReq);

  // R2
  read_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busReq && busCmd == 2'b01) |-> !cpuWe);

  // R4
  own_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busReq && (busCmd == 2'b10 || busCmd == 2'b11)) |-> cpuWe);

  // R7
  single_abort_chk: assert property (@(posedge clk) disable iff (rst)
    snpAbort |=> !(snpAbort && snpAddr == $past(snpAddr)));
endmodule

bind snoop_coherence_ctrl coh_ctrl_chk #(.ADDR_W(ADDR_W)) i_coh_ctrl_chk (
  .clk     (clk),
  .rst     (rst),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuReady(cpuReady),
  .busReq  (busReq),
  .busCmd  (busCmd),
  .snpValid(snpValid),
  .snpAddr (snpAddr),
  .snpAbort(snpAbort)
);

// File: tb/test_snoop_coherence_ctrl.sv
module test_snoop_coherence_ctrl;
  timeunit 1ns; timeprecision 100ps;
  import coh_pkg::*;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 4;

  logic clk = 0, rst = 1;
  logic cpuReq = 0, cpuWe = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuReady;
  logic [DW-1:0] cpuRdata;
  logic busReq;
  logic [1:0] busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic busAck = 0;
  logic [DW-1:0] busRdata = '0;
  logic snpValid = 0;
  logic [1:0] snpCmd = 2'b00;
  logic [AW-1:0] snpAddr = '0;
  logic snpAbort;
  logic [DW-1:0] snpData;

  always #2.5 clk = ~clk;

  snoop_coherence_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_snoop_coherence_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .busReq(busReq),
    .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpAbort(snpAbort), .snpData(snpData));

  int errors = 0, checks = 0;
  logic [DW-1:0] mem [256];
  lineState_t    mSt [NL];
  logic [AW-1:0] mAd [NL];
  logic [DW-1:0] mDa [NL];
  logic hold = 0;
  int waitCnt = 0;
  logic [1:0] logCmd [8];
  int logN = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus responder standing in for memory
  always @(negedge clk) begin
    if (busAck) busAck = 0;
    else if (!rst && busReq && !hold && !snpValid) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        busAck   = 1;
        busRdata = mem[busAddr];
        if (logN < 8) logCmd[logN] = busCmd;
        logN++;
        if (busCmd == 2'b00) mem[busAddr] = busWdata;
        waitCnt = $urandom_range(2, 0);
      end
    end
  end

  function automatic bit holds(input logic [AW-1:0] a);
    return mSt[a % NL] != LINE_INV && mAd[a % NL] == a;
  endfunction

  task automatic cpuOp(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string req);
    int ix = int'(a) % NL;
    bit h = holds(a);
    lineState_t s = h ? mSt[ix] : LINE_INV;
    bit expWb = !h && mSt[ix] == LINE_MOD;
    logic [AW-1:0] vA = mAd[ix];
    logic [DW-1:0] vD = mDa[ix];
    logic [DW-1:0] expRd = h ? mDa[ix] : mem[a];
    int expN = 0;
    logic [1:0] expLast = 2'b01;
    logic [DW-1:0] got;
    if (!we) begin expN = h ? 0 : 1; expLast = 2'b01; end
    else if (s == LINE_MOD) expN = 0;
    else if (s == LINE_SHR) begin expN = 1; expLast = 2'b11; end
    else begin expN = 1; expLast = 2'b10; end
    if (expWb) expN++;
    @(negedge clk);
    logN = 0;
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
    end
    got = cpuRdata;
    @(negedge clk);
    cpuReq = 0;
    chk(logN == expN, req, "bus transaction count", logN, expN);
    if (expN > 0 && logN == expN)
      chk(logCmd[expN-1] == expLast, req, "bus command", logCmd[expN-1], expLast);
    if (expWb) begin
      chk(logCmd[0] == 2'b00, "R9", "write-back first", logCmd[0], 0);
      chk(mem[vA] == vD, "R9", "written-back value", mem[vA], vD);
    end
    if (!we) chk(got == expRd, req, "read data", got, expRd);
    mSt[ix] = we ? LINE_MOD : (h ? s : LINE_SHR);
    mAd[ix] = a;
    mDa[ix] = we ? d : expRd;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input string req);
    int ix = int'(a) % NL;
    bit h = holds(a);
    bit expAbort = h && mSt[ix] == LINE_MOD && (cmd == 2'b01 || cmd == 2'b10);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    #1;
    chk(snpAbort == expAbort, req, "snoop cancel", snpAbort, expAbort);
    if (expAbort) chk(snpData == mDa[ix], req, "supplied data", snpData, mDa[ix]);
    @(negedge clk);
    snpValid = 0;
    if (expAbort) mem[a] = mDa[ix];
    if (h) begin
      if (cmd == 2'b01) mSt[ix] = LINE_SHR;
      else if (cmd != 2'b00) mSt[ix] = LINE_INV;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    void'($urandom(32'd7919));
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    for (int i = 0; i < NL; i++) begin mSt[i] = LINE_INV; mAd[i] = '0; mDa[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(busReq == 0 && cpuReady == 0 && snpAbort == 0, "R1", "idle outputs after reset",
        {busReq, cpuReady, snpAbort}, 0);

    snoop(2'b01, 8'd5, "R1");
    cpuOp(0, 8'd5, 0, "R2");
    snoop(2'b01, 8'd5, "R8");
    cpuOp(1, 8'd5, 16'h1111, "R4");
    cpuOp(1, 8'd5, 16'h2222, "R3");
    cpuOp(1, 8'd9, 16'h3333, "R9");
    snoop(2'b01, 8'd9, "R6");
    cpuOp(1, 8'd9, 16'h3434, "R6");
    snoop(2'b10, 8'd9, "R7");
    cpuOp(0, 8'd9, 0, "R5");
    cpuOp(0, 8'd13, 0, "R9");
    snoop(2'b11, 8'd13, "R5");
    cpuOp(0, 8'd13, 0, "R5");

    // R10: snoop and local hit arrive together
    cpuOp(1, 8'd2, 16'h5A5A, "R3");
    @(negedge clk);
    cpuReq = 1; cpuWe = 0; cpuAddr = 8'd2;
    snpValid = 1; snpCmd = 2'b01; snpAddr = 8'd2;
    #1;
    chk(cpuReady == 0, "R10", "no completion during snoop", cpuReady, 0);
    chk(snpAbort == 1 && snpData == 16'h5A5A, "R10", "intervention data", snpData, 16'h5A5A);
    @(negedge clk);
    snpValid = 0;
    #1;
    got = cpuRdata;
    chk(cpuReady == 1 && got == 16'h5A5A, "R10", "stalled read completes", got, 16'h5A5A);
    @(negedge clk);
    cpuReq = 0;
    mem[2] = 16'h5A5A; mSt[2] = LINE_SHR;

    // R11: pending invalidate loses its block
    hold = 1;
    @(negedge clk);
    logN = 0;
    cpuReq = 1; cpuWe = 1; cpuAddr = 8'd2; cpuWdata = 16'h4444;
    @(negedge clk);
    #1;
    chk(busReq == 1 && busCmd == 2'b11, "R11", "invalidate pending", busCmd, 3);
    @(negedge clk);
    snpValid = 1; snpCmd = 2'b11; snpAddr = 8'd2;
    #1;
    chk(snpAbort == 0, "R11", "no cancel on invalidate", snpAbort, 0);
    @(negedge clk);
    snpValid = 0;
    for (int k = 0; k < 10 && !busReq; k++) @(negedge clk);
    #1;
    chk(busReq == 1 && busCmd == 2'b10, "R11", "reissued as read-for-ownership", busCmd, 2);
    hold = 0;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 0;
    mSt[2] = LINE_MOD; mAd[2] = 8'd2; mDa[2] = 16'h4444;
    cpuOp(0, 8'd2, 0, "R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(9, 0);
      logic [AW-1:0] a = AW'($urandom_range(15, 0));
      if (r < 4) cpuOp(0, a, 0, "R2");
      else if (r < 7) cpuOp(1, a, DW'($urandom), "R3");
      else snoop(2'($urandom_range(3, 0)), a, "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule